// File: doc/BRIEF.md
# LIN Wake-up Request Transmitter

This block asks a sleeping LIN cluster to wake up by driving the dominant (low) level onto the transmit line for a fixed run of bit times. It does this by sending one ordinary UART character. The character is chosen so that its start bit and its leading zero data bits together form that dominant run. A mode input selects the pattern for the newer or the older protocol revision. The block takes its bit timing from an external one-cycle bit-period tick, so any baud generator can drive it.

A one-cycle start pulse requests a transfer. The block then waits for the next tick, so the start bit lasts a full bit period. It sends the frame and drops busy when the stop bit has ended. At that point it raises a sticky completion flag. Software-side logic clears the flag with a separate one-cycle clear pulse. The block has no data stream: every pin is a plain control or status signal.

Top module: `lin_wakeup_tx`

## Requirements
- R1: After reset, `txd` is high (recessive), `busy` is low and `done_flag` is low, and `txd` stays high whenever `busy` is low.
- R2: A `start_pulse` seen while `busy` is low makes `busy` high on the next cycle. The start bit begins at the first `bit_tick` after that, and each bit then holds until the following `bit_tick`.
- R3: The frame on `txd` is one low start bit, then `CHAR_W` data bits with the least significant bit first, then one high stop bit.
- R4: With `mode_legacy` = 0 the character is 0xF0 (the upper half of the bits set). This gives exactly 5 bit periods of low level: the start bit and four zero data bits.
- R5: With `mode_legacy` = 1 the character is 0x80 (only the most significant bit set). This gives exactly 8 bit periods of low level: the start bit and seven zero data bits.
- R6: `mode_legacy` is sampled only together with an accepted start pulse. Changing it while `busy` is high does not alter the character being sent.
- R7: A `start_pulse` while `busy` is high is ignored. It neither restarts nor extends the transfer, and it does not queue a second one.
- R8: On the `bit_tick` that ends the stop bit, `busy` falls and `done_flag` rises on the next cycle.
- R9: `done_flag` stays high until a `clr_status` pulse, and it is low on the cycle after that pulse.
- R10: If `clr_status` arrives in the same cycle as the completion, `done_flag` is set and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| mode_legacy | input | 1 | 0: 5-bit dominant pattern, 1: 8-bit dominant pattern |
| start_pulse | input | 1 | One-cycle request to send a wake-up character |
| clr_status | input | 1 | One-cycle clear of the completion flag |
| txd | output | 1 | Serial transmit line, idles high |
| busy | output | 1 | High from an accepted start until the stop bit ends |
| done_flag | output | 1 | Sticky transfer-complete flag |

## Verification
The bench builds the block with the default 8-bit character and drives `bit_tick` every 5 clocks. This makes each bit period several cycles long, so the length of the dominant run can be measured in cycles and compared against 5 or 8 bit periods. It also leaves room to place start pulses and mode changes in the middle of a bit. The short period keeps each frame to about 55 cycles. With frames that short, the bench can line up a clear pulse with the exact completion cycle and can send repeated start pulses inside a single transfer.

// File: rtl/lin_wkup_pkg.sv
package lin_wkup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } wk_state_e;

  // Bit idx of the wake-up character for a given width.
  // Newer revision: upper half set (0xF0 at 8 bits).
  // Older revision: only the top bit set (0x80 at 8 bits).
  function automatic logic wake_bit(input logic legacy, input int idx, input int width);
    if (legacy) return (idx == width - 1);
    return (idx >= width / 2);
  endfunction

endpackage

// File: rtl/lin_wkup_ctrl.sv
module lin_wkup_ctrl
  import lin_wkup_pkg::*;
#(
  parameter int FRAME_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic start_pulse,
  input  logic mode_in,
  output logic busy,
  output logic sending,
  output logic load,
  output logic shift,
  output logic done_evt,
  output logic mode_q
);

  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  wk_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_pulse) begin
            state_q <= ST_ARMED;
            mode_q  <= mode_in;
          end
        end
        ST_ARMED: begin
          if (bit_tick) begin
            state_q <= ST_SEND;
            cnt_q   <= '0;
          end
        end
        ST_SEND: begin
          if (bit_tick) begin
            if (cnt_q == LAST) state_q <= ST_IDLE;
            else               cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (state_q != ST_IDLE);
    sending  = (state_q == ST_SEND);
    load     = (state_q == ST_ARMED) && bit_tick;
    shift    = sending && bit_tick && (cnt_q != LAST);
    done_evt = sending && bit_tick && (cnt_q == LAST);
  end

  // R2: an accepted start arms the transfer on the next cycle
  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_pulse) |=> busy);

  // R7: a start during the frame leaves the bit position untouched
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && start_pulse && !bit_tick) |=> (sending && $stable(cnt_q)));

  // R6: the selected pattern is frozen for the whole transfer
  a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

endmodule

// File: rtl/lin_wkup_serializer.sv
module lin_wkup_serializer
  import lin_wkup_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic shift,
  input  logic sending,
  input  logic legacy,
  output logic txd
);

  localparam int FRAME_BITS = CHAR_W + 2;

  logic [CHAR_W-1:0]     char_w;
  logic [FRAME_BITS-1:0] frame_q;

  for (genvar i = 0; i < CHAR_W; i++) begin : g_char
    assign char_w[i] = wake_bit(legacy, i, CHAR_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
    end else if (load) begin
      frame_q <= {1'b1, char_w, 1'b0};
    end else if (shift) begin
      frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
    end
  end

  assign txd = sending ? frame_q[0] : 1'b1;

  // R3: every frame opens with a dominant start bit
  a_r3_start_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> !txd);

endmodule

// File: rtl/lin_wkup_flag.sv
module lin_wkup_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  // R10: completion dominates a coincident clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);

  // R9: sticky until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);

endmodule

// File: rtl/lin_wakeup_tx.sv
module lin_wakeup_tx #(
  parameter int CHAR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic mode_legacy,
  input  logic start_pulse,
  input  logic clr_status,
  output logic txd,
  output logic busy,
  output logic done_flag
);

  localparam int FRAME_BITS = CHAR_W + 2;

  logic sending, load, shift, done_evt, mode_q;

  lin_wkup_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .start_pulse (start_pulse),
    .mode_in     (mode_legacy),
    .busy        (busy),
    .sending     (sending),
    .load        (load),
    .shift       (shift),
    .done_evt    (done_evt),
    .mode_q      (mode_q)
  );

  lin_wkup_serializer #(.CHAR_W(CHAR_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .shift   (shift),
    .sending (sending),
    .legacy  (mode_q),
    .txd     (txd)
  );

  lin_wkup_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (done_evt),
    .clr    (clr_status),
    .flag_q (done_flag)
  );

  // R8: end of stop bit releases busy and raises the flag together
  a_r8_done_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy && done_flag));

  // R1: the line is recessive whenever no transfer is in flight
  a_r1_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

endmodule

// File: tb/tb_lin_wakeup_tx.sv
module tb_lin_wakeup_tx;

  localparam int CHAR_W   = 8;
  localparam int TICK_DIV = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic mode_legacy = 1'b0;
  logic start_pulse = 1'b0;
  logic clr_status = 1'b0;
  logic txd, busy, done_flag;

  int checks = 0;
  int errors = 0;

  lin_wakeup_tx #(.CHAR_W(CHAR_W)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mode_legacy(mode_legacy),
    .start_pulse(start_pulse), .clr_status(clr_status),
    .txd(txd), .busy(busy), .done_flag(done_flag)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bit-period tick generator
  int tcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      tcnt = 0;
      bit_tick = 1'b0;
    end else begin
      tcnt = (tcnt + 1) % TICK_DIV;
      bit_tick = (tcnt == 0);
    end
  end

  // behavioural reference model: 0 idle, 1 waiting for tick, 2 on the line
  int m_st = 0;
  bit m_bits[$];
  bit m_flag = 1'b0;
  bit m_mode = 1'b0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_bits.delete(); m_flag = 1'b0; m_mode = 1'b0;
    end else begin
      bit fin;
      fin = 1'b0;
      if (m_st == 0) begin
        if (start_pulse) begin m_st = 1; m_mode = mode_legacy; end
      end else if (m_st == 1) begin
        if (bit_tick) begin
          int ch;
          ch = m_mode ? 8'h80 : 8'hF0;
          m_bits.delete();
          m_bits.push_back(1'b0);
          for (int i = 0; i < CHAR_W; i++) m_bits.push_back(ch[i]);
          m_bits.push_back(1'b1);
          m_st = 2;
        end
      end else begin
        if (bit_tick) begin
          if (m_bits.size() == 1) begin m_st = 0; fin = 1'b1; m_bits.delete(); end
          else void'(m_bits.pop_front());
        end
      end
      if (fin) m_flag = 1'b1;
      else if (clr_status) m_flag = 1'b0;
    end
  end

  // per-cycle comparison and dominant-run measurement
  int run = 0;
  int last_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 txd", txd, (m_st == 2) ? m_bits[0] : 1'b1);
      chk("R2/R7 busy", busy, m_st != 0);
      chk("R9 done_flag", done_flag, m_flag);
      if (txd === 1'b0) run++;
      else begin
        if (run > 0) last_run = run;
        run = 0;
      end
    end
  end

  task automatic pulse_start(input logic m);
    @(negedge clk);
    mode_legacy = m;
    start_pulse = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy !== 1'b0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset flag", done_flag, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle txd", txd, 1'b1);

    // newer-revision pattern
    pulse_start(1'b0);
    chk("R2 busy after start", busy, 1'b1);
    chk("R2 line still idle before tick", txd, 1'b1);
    wait_idle();
    chk_int("R4 dominant run cycles", last_run, 5 * TICK_DIV);
    chk("R8 flag after completion", done_flag, 1'b1);
    chk("R8 busy released", busy, 1'b0);

    // sticky flag and clear
    repeat (20) @(negedge clk);
    chk("R9 flag held", done_flag, 1'b1);
    pulse_clr();
    chk("R9 flag cleared", done_flag, 1'b0);

    // older-revision pattern
    pulse_start(1'b1);
    wait_idle();
    chk_int("R5 dominant run cycles", last_run, 8 * TICK_DIV);
    pulse_clr();

    // mode changed mid-transfer
    pulse_start(1'b0);
    repeat (7) @(negedge clk);
    mode_legacy = 1'b1;
    wait_idle();
    chk_int("R6 run unaffected by mode change", last_run, 5 * TICK_DIV);
    pulse_clr();

    // starts during a transfer are ignored
    pulse_start(1'b1);
    repeat (3) @(negedge clk);
    pulse_start(1'b0);
    repeat (17) @(negedge clk);
    pulse_start(1'b0);
    wait_idle();
    chk_int("R7 run of first request only", last_run, 8 * TICK_DIV);
    for (int i = 0; i < 3 * TICK_DIV; i++) begin
      @(negedge clk);
      chk("R7 no queued transfer", busy, 1'b0);
    end
    pulse_clr();

    // clear coinciding with completion
    pulse_start(1'b0);
    @(negedge clk); #1;
    while (!(m_st == 2 && m_bits.size() == 1 && bit_tick)) begin
      @(negedge clk); #1;
    end
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    chk("R10 completion wins over clear", done_flag, 1'b1);
    chk("R10 busy released", busy, 1'b0);
    repeat (5) @(negedge clk);
    chk("R10 flag still set", done_flag, 1'b1);

    finish_run();
  end

endmodule